// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block gathers a bank of input-only external signals and turns them into one combined interrupt line. Each input passes through a two-flop synchroniser and then through its own debounce filter. The filter counts a shared millisecond tick and accepts a new level only after that level has held for a programmed number of ticks. An input's filter stays idle until software arms it with a start pulse. Once armed, the filtered level is compared with a per-input polarity bit. While the two match, a sticky status bit is set.

Software reaches the block through a single-cycle register port: an address, a write enable, write data and registered read data. Through this port it reads the gated input levels and sets the data enables, polarities, interrupt enables and debounce times. It also reads raw and masked status, clears status bits by writing ones, and arms the filters. The interrupt output is a registered OR of all masked status bits.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, no filter is armed, and `irq_out` is low.
- R2: The data register (0x00) returns the filtered level for each input whose bit is set in the data-enable register (0x04), and 0 for every other input. Writes to 0x00 change nothing, because the inputs cannot be driven.
- R3: When an input's debounce time is 0, an armed filter follows the synchronised level. A pin change shows in the filtered level three clock edges after it is applied.
- R4: When an input's debounce time is N > 0, a new level is accepted only after it has differed from the filtered level through N ticks. A change that reverts before that point is discarded.
- R5: An input's filtered level stays 0 and its status never sets until a 1 is written to its bit in the trigger register (0x28). Writing that 1 arms the input permanently. The trigger register reads 0.
- R6: The polarity register (0x14) sets each input's active level: a bit of 1 means active-high and a bit of 0 means active-low. The raw status bit of an armed input sets while its filtered level equals its polarity bit.
- R7: Raw status (0x1C) is sticky and read-only. Writing 1 to a bit of the clear register (0x24) clears that bit on that edge; writing 0 has no effect. If the level is still active, the bit sets again on the following edge.
- R8: Masked status (0x20) reads raw status ANDed with the interrupt-enable register (0x18).
- R9: `irq_out` is high one cycle after any masked status bit is set.
- R10: Input n's control word sits at 0x40 + 4n. Bits 11:0 hold the debounce time in ticks, and the upper bits read 0.
- R11: Bit n of every per-input register belongs to input n, and only bits 15:0 are stored. Read data is registered, so it reflects the state before the sampling edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 16 | Asynchronous external inputs |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
A write to the clear register can land in the same cycle in which the filtered level of that input is still active. The two disagree over the next value of the status bit. The bench provokes this by clearing an active-high input while its pin stays high, then reading raw status on the very next cycle and again on the one after. The first read must show the bit cleared, because the clear wins its edge. The second read must show it set again, because the live level re-asserts it.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int A_DATA = 'h00;
  localparam int A_DEN  = 'h04;
  localparam int A_POL  = 'h14;
  localparam int A_IE   = 'h18;
  localparam int A_RAW  = 'h1C;
  localparam int A_MSK  = 'h20;
  localparam int A_CLR  = 'h24;
  localparam int A_TRG  = 'h28;
  localparam int A_CTL  = 'h40;
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/lic_tick.sv
module lic_tick #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lic_dbnc.sv
module lic_dbnc #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          tick,
  input  logic          din,
  input  logic [DW-1:0] limit,
  output logic          filt
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= 1'b0;
      cnt  <= '0;
    end else if (arm) begin
      if (din == filt) begin
        cnt <= '0;
      end else if (limit == '0) begin
        filt <= din;
        cnt  <= '0;
      end else if (tick) begin
        if (DW'(cnt + 1'b1) >= limit) begin
          filt <= din;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: a filtered level moves only on a tick, or when the debounce time is zero
  a_r4_accept_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> ($past(tick) || ($past(limit) == '0)));

  // R5: an idle filter holds 0
  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !arm |-> !filt);
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int N        = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DW       = 12,
  parameter int TICK_DIV = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  import lic_pkg::*;

  localparam int IDXW    = (N > 1) ? $clog2(N) : 1;
  localparam int CTL_END = A_CTL + 4 * N;

  logic [N-1:0] den_q, pol_q, ie_q, raw_q, armed_q, trg_q;
  logic [DW-1:0] ctl_q [N];
  logic [N-1:0] sync_v, filt_v, active_v, clr_mask;
  logic tick;

  logic [ADDR_W-1:0] ctl_off;
  logic              ctl_hit;
  logic [IDXW-1:0]   ctl_idx;
  logic [DATA_W-1:0] rd_next;

  lic_sync #(.W(N)) u_sync (.clk(clk), .rst(rst), .d(pin_in), .q(sync_v));
  lic_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  for (genvar g = 0; g < N; g++) begin : g_flt
    lic_dbnc #(.DW(DW)) u_dbnc (
      .clk(clk), .rst(rst), .arm(armed_q[g]), .tick(tick),
      .din(sync_v[g]), .limit(ctl_q[g]), .filt(filt_v[g])
    );
  end

  // address decode of the per-input control words
  always_comb begin
    ctl_off = bus_addr - ADDR_W'(A_CTL);
    ctl_hit = (int'(bus_addr) >= A_CTL) && (int'(bus_addr) < CTL_END) &&
              (ctl_off[1:0] == 2'b00);
    ctl_idx = ctl_off[IDXW+1:2];
  end

  assign active_v = armed_q & ~(filt_v ^ pol_q);
  assign clr_mask = (bus_we && int'(bus_addr) == A_CLR) ? bus_wdata[N-1:0] : '0;

  // configuration writes
  always_ff @(posedge clk) begin
    if (rst) begin
      den_q <= '0;
      pol_q <= '0;
      ie_q  <= '0;
      trg_q <= '0;
    end else begin
      trg_q <= '0;
      if (bus_we) begin
        case (int'(bus_addr))
          A_DEN:   den_q <= bus_wdata[N-1:0];
          A_POL:   pol_q <= bus_wdata[N-1:0];
          A_IE:    ie_q  <= bus_wdata[N-1:0];
          A_TRG:   trg_q <= bus_wdata[N-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ctl_q[i] <= '0;
    end else if (bus_we && ctl_hit) begin
      ctl_q[ctl_idx] <= bus_wdata[DW-1:0];
    end
  end

  // arming, sticky status and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= '0;
      raw_q   <= '0;
      irq_out <= 1'b0;
    end else begin
      armed_q <= armed_q | trg_q;
      raw_q   <= (raw_q | active_v) & ~clr_mask;
      irq_out <= |(raw_q & ie_q);
    end
  end

  // registered read port
  always_comb begin
    rd_next = '0;
    case (int'(bus_addr))
      A_DATA: rd_next[N-1:0] = filt_v & den_q;
      A_DEN:  rd_next[N-1:0] = den_q;
      A_POL:  rd_next[N-1:0] = pol_q;
      A_IE:   rd_next[N-1:0] = ie_q;
      A_RAW:  rd_next[N-1:0] = raw_q;
      A_MSK:  rd_next[N-1:0] = raw_q & ie_q;
      default: if (ctl_hit) rd_next[DW-1:0] = ctl_q[ctl_idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R7: a cleared bit is low right after the clear edge
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((raw_q & $past(clr_mask)) == '0));

  // R7: a set bit stays set unless it was cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (|raw_q) |=> (((($past(raw_q) & ~$past(clr_mask))) & ~raw_q) == '0));

  // R5: status only for armed inputs
  a_r5_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & ~armed_q) == '0));

  // R9: an interrupt needs some enable bit in the cycle before
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (|$past(ie_q)));
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pin_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  logic [31:0] r;

  // {address, write data, expected read-back}
  localparam logic [71:0] VEC [NV] = '{
    {8'h04, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R11 only 16 bits stored
    {8'h14, 32'h0000_A5A5, 32'h0000_A5A5},  // R11
    {8'h18, 32'h1234_5678, 32'h0000_5678},  // R11
    {8'h40, 32'hFFFF_FFFF, 32'h0000_0FFF},  // R10 upper bits read 0
    {8'h7C, 32'h0000_ABCD, 32'h0000_0BCD},  // R10 last control word
    {8'h28, 32'h0000_0000, 32'h0000_0000},  // R5 trigger reads 0
    {8'h00, 32'h0000_FFFF, 32'h0000_0000},  // R2 data write ignored
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 raw is read-only
    {8'h30, 32'hFFFF_FFFF, 32'h0000_0000}   // R11 unmapped
  };

  always #(CLK_PERIOD / 2) clk = ~clk;

  lvl_irq_ctrl #(.TICK_DIV(4)) u_lvl_irq_ctrl (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_up();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    bus_read(8'h04, r); check("R1 den", r, 32'h0);
    bus_read(8'h1C, r); check("R1 raw", r, 32'h0);
    bus_read(8'h44, r); check("R1 ctl", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][71:64], VEC[i][63:32]);
      bus_read(VEC[i][71:64], r);
      check("R11 table", r, VEC[i][31:0]);
    end

    // setup: inputs 0..3 active-high, 4..15 active-low, no debounce
    bus_write(8'h04, 32'hFFFF);
    bus_write(8'h14, 32'h000F);
    bus_write(8'h18, 32'h0);
    for (int i = 0; i < 16; i++) bus_write(8'h40 + 8'(4 * i), 32'h0);
    pin_in = 16'h0001;
    wait_cyc(6);
    bus_read(8'h00, r); check("R5 idle data", r, 32'h0);
    bus_read(8'h1C, r); check("R5 idle raw", r, 32'h0);

    // arm all inputs
    bus_write(8'h28, 32'hFFFF);
    wait_cyc(5);
    bus_read(8'h00, r); check("R5 armed data", r, 32'h0001);
    bus_read(8'h1C, r); check("R6 raw polarity", r, 32'hFFF1);
    bus_read(8'h20, r); check("R8 masked none", r, 32'h0);
    check("R9 irq low", {31'b0, irq_out}, 32'h0);

    bus_write(8'h18, 32'h0030);
    wait_cyc(2);
    bus_read(8'h20, r); check("R8 masked", r, 32'h0030);
    check("R9 irq high", {31'b0, irq_out}, 32'h1);

    // R3 exact pass-through latency
    pin_in = 16'hFFF1;
    wait_cyc(3);
    bus_read(8'h00, r); check("R3 latency", r, 32'hFFF1);
    bus_read(8'h1C, r); check("R7 sticky", r, 32'hFFF1);

    bus_write(8'h24, 32'h0);
    bus_read(8'h1C, r); check("R7 clear zero", r, 32'hFFF1);

    // clear collides with a still-active input 0
    bus_write(8'h24, 32'hFFFF);
    bus_read(8'h1C, r); check("R7 clear wins", r, 32'h0);
    bus_read(8'h1C, r); check("R7 re-set", r, 32'h0001);
    wait_cyc(1);
    check("R9 irq cleared", {31'b0, irq_out}, 32'h0);

    // R4 debounce of input 8, 3 ticks of 4 cycles
    bus_write(8'h60, 32'h3);
    pin_in[8] = 1'b0;
    wait_cyc(4);
    bus_read(8'h00, r); check("R4 held", r, 32'hFFF1);
    wait_cyc(20);
    bus_read(8'h00, r); check("R4 accepted", r, 32'hFEF1);
    pin_in[8] = 1'b1;
    wait_cyc(6);
    pin_in[8] = 1'b0;
    wait_cyc(30);
    bus_read(8'h00, r); check("R4 glitch dropped", r, 32'hFEF1);

    // R6 flip polarity of input 1 (pin low) to active-low
    bus_write(8'h24, 32'hFFFF);
    bus_write(8'h14, 32'h000D);
    wait_cyc(3);
    bus_read(8'h1C, r); check("R6 polarity flip", r, 32'h0103);

    // R2 data enable gating and ignored data write
    bus_write(8'h04, 32'h00FF);
    bus_write(8'h00, 32'hFFFF);
    bus_read(8'h00, r); check("R2 gated data", r, 32'h00F1);
    bus_read(8'h04, r); check("R2 den kept", r, 32'h00FF);

    finish_up();
  end
endmodule